// File: doc/BRIEF.md
# Loop Bandwidth and Hitless-Switch Sequencer

This block is the control state machine beside a clock-synthesis phase-locked loop. On every cycle of its sampling clock it decides two things: whether the loop filter runs in its wide or its narrow bandwidth setting, and whether the phase comparator is allowed to correct the oscillator. It takes its lock information from a separate lock detector. That detector supplies a loss-of-lock level, a strobe once per comparator cycle, and a flag that says the phase error is inside the tight window.

Two mechanisms drive the bandwidth. The first is a power-up override. When the override is enabled, a narrow-bandwidth request is honoured only after the loop has shown a clean lock history. When the override is disabled, the loop is pinned to wide bandwidth. The second is an optional hitless sequence, triggered by a fresh loss of lock. The sequence gates the comparator off and holds the loop narrow. If phase build-out is enabled, it asks for a feedback-edge realignment and waits for it. It then re-enables the comparator, waits for a run of in-window cycles, runs a short revert timer, and re-arms.

Top module: `lbw_hitless_seq`

## Requirements
- R1: After a synchronous reset, narrow_bw is 0, pd_enable is 1 and align_req is 0.
- R2: While init_en is 0, narrow_bw is 0 one cycle later, even when narrow_req is 1 and even during a hitless sequence.
- R3: With init_en at 1, a narrow_req of 1 selects narrow bandwidth only after LOCK_RUN consecutive pd_strobe pulses with lol at 0. Any cycle with lol at 1 restarts that count. Once reached, the condition holds until init_en goes to 0 or reset.
- R4: With narrow_req at 0 and no hitless sequence running, narrow_bw is 0.
- R5: The hitless function arms only when hs_enable is 1 and a pd_strobe arrives with lol at 0. Before that, or with hs_enable at 0, a rising lol leaves the outputs unchanged.
- R6: When armed, a 0-to-1 transition of lol holds the comparator off for one cycle. The outputs show pd_enable 0 and narrow_bw 1 two cycles after the rising lol.
- R7: With pbo_enable at 1 at the end of that hold cycle, align_req rises and pd_enable stays 0 until align_done is seen. With pbo_enable at 0, align_req stays 0 and pd_enable returns to 1 a cycle after it fell. align_req is never high while pd_enable is high.
- R8: If align_done never arrives, align_req stays high for exactly ALIGN_TMO cycles, and then pd_enable returns to 1.
- R9: After the comparator is re-enabled, the sequence needs LOCK_RUN consecutive pd_strobe pulses with in_window at 1. A strobe with in_window at 0 resets the count to zero.
- R10: Once that run is complete, narrow bandwidth is held for REVERT_TICKS further cycles (the revert time in sampling-clock ticks). The block then returns to wide bandwidth and re-arms, so the next rising lol triggers a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| init_en | input | 1 | Power-up override enable; 0 forces wide bandwidth |
| narrow_req | input | 1 | Static request for narrow bandwidth |
| hs_enable | input | 1 | Hitless-switch option enable |
| pbo_enable | input | 1 | Phase build-out option enable |
| lol | input | 1 | Loss-of-lock level from the lock detector |
| pd_strobe | input | 1 | One-cycle pulse per phase-comparator cycle |
| in_window | input | 1 | Phase error inside the tight window, valid with pd_strobe |
| align_done | input | 1 | Feedback-edge realignment finished |
| narrow_bw | output | 1 | 1 selects the narrow loop bandwidth |
| pd_enable | output | 1 | 1 lets the phase comparator drive the loop |
| align_req | output | 1 | Request to realign the feedback edge |

## Verification
The bench probes the run counters at their edges. It interrupts the lock history with a single lol cycle and a single out-of-window strobe. A design that does not restart the run would go narrow or revert several strobes too early. The revert timer and the realignment timeout are each checked on the exact cycle they end, which catches any off-by-one in the tick counts. Further checks raise lol before any locked strobe, with the option disabled, and while init_en is 0. A design that arms too eagerly, or lets the hitless sequence bypass the override, would show a spurious comparator gap or narrow setting.

// File: rtl/lbw_pkg.sv
package lbw_pkg;

  typedef enum logic [2:0] {
    HS_IDLE   = 3'd0,
    HS_ARMED  = 3'd1,
    HS_HOLD   = 3'd2,
    HS_ALIGN  = 3'd3,
    HS_RELOCK = 3'd4,
    HS_REVERT = 3'd5
  } hs_state_e;

  function automatic logic hs_forces_narrow(hs_state_e s);
    return (s == HS_HOLD) || (s == HS_ALIGN) || (s == HS_RELOCK) || (s == HS_REVERT);
  endfunction

  function automatic logic hs_gates_pd(hs_state_e s);
    return (s == HS_HOLD) || (s == HS_ALIGN);
  endfunction

endpackage

// File: rtl/lbw_run_counter.sv
module lbw_run_counter #(
  parameter int TARGET = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic strobe,
  input  logic good,
  output logic reached
);
  localparam int CW = $clog2(TARGET + 1);

  logic [CW-1:0] run_q;

  assign reached = (run_q == CW'(TARGET));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q <= '0;
    end else if (strobe) begin
      if (!good)
        run_q <= '0;
      else if (!reached)
        run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/lbw_dwell_timer.sv
module lbw_dwell_timer #(
  parameter int MAX_TICKS = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [$clog2(MAX_TICKS+1)-1:0] load_val,
  output logic                           expired
);
  localparam int TW = $clog2(MAX_TICKS + 1);

  logic [TW-1:0] left_q;

  assign expired = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= '0;
    else if (load)
      left_q <= load_val;
    else if (!expired)
      left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/lbw_init_guard.sv
module lbw_init_guard #(
  parameter int LOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic init_en,
  input  logic lol,
  input  logic pd_strobe,
  output logic history_ok
);
  logic run_met;

  // any lol cycle restarts the clean-lock count
  lbw_run_counter #(.TARGET(LOCK_RUN)) u_run (
    .clk     (clk),
    .rst     (rst),
    .clr     (!init_en || lol),
    .strobe  (pd_strobe),
    .good    (!lol),
    .reached (run_met)
  );

  always_ff @(posedge clk) begin
    if (rst || !init_en)
      history_ok <= 1'b0;
    else if (run_met)
      history_ok <= 1'b1;
  end
endmodule

// File: rtl/lbw_hs_fsm.sv
module lbw_hs_fsm
  import lbw_pkg::*;
#(
  parameter int LOCK_RUN     = 8,
  parameter int ALIGN_TMO    = 16,
  parameter int REVERT_TICKS = 9
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      hs_enable,
  input  logic      pbo_enable,
  input  logic      lol,
  input  logic      pd_strobe,
  input  logic      in_window,
  input  logic      align_done,
  output hs_state_e state
);
  localparam int TMAX = (ALIGN_TMO > REVERT_TICKS) ? ALIGN_TMO : REVERT_TICKS;
  localparam int TW   = $clog2(TMAX + 1);

  hs_state_e nxt;
  logic      lol_q;
  logic      lol_rise;
  logic      run_met;
  logic      t_load;
  logic [TW-1:0] t_val;
  logic      t_expired;

  assign lol_rise = lol && !lol_q;

  lbw_run_counter #(.TARGET(LOCK_RUN)) u_win_run (
    .clk     (clk),
    .rst     (rst),
    .clr     (state != HS_RELOCK),
    .strobe  (pd_strobe),
    .good    (in_window),
    .reached (run_met)
  );

  lbw_dwell_timer #(.MAX_TICKS(TMAX)) u_dwell (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      HS_IDLE:
        if (hs_enable && pd_strobe && !lol) nxt = HS_ARMED;
      HS_ARMED:
        if (!hs_enable)    nxt = HS_IDLE;
        else if (lol_rise) nxt = HS_HOLD;
      HS_HOLD:
        if (pbo_enable) begin
          nxt    = HS_ALIGN;
          t_load = 1'b1;
          t_val  = TW'(ALIGN_TMO - 1);
        end else begin
          nxt = HS_RELOCK;
        end
      HS_ALIGN:
        if (align_done || t_expired) nxt = HS_RELOCK;
      HS_RELOCK:
        if (run_met) begin
          nxt    = HS_REVERT;
          t_load = 1'b1;
          t_val  = TW'(REVERT_TICKS - 1);
        end
      HS_REVERT:
        if (t_expired) nxt = HS_ARMED;
      default:
        nxt = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HS_IDLE;
      lol_q <= 1'b1;
    end else begin
      state <= nxt;
      lol_q <= lol;
    end
  end
endmodule

// File: rtl/lbw_hitless_seq.sv
module lbw_hitless_seq
  import lbw_pkg::*;
#(
  parameter int LOCK_RUN     = 8,
  parameter int ALIGN_TMO    = 16,
  parameter int REVERT_TICKS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic init_en,
  input  logic narrow_req,
  input  logic hs_enable,
  input  logic pbo_enable,
  input  logic lol,
  input  logic pd_strobe,
  input  logic in_window,
  input  logic align_done,
  output logic narrow_bw,
  output logic pd_enable,
  output logic align_req
);
  hs_state_e hs_state;
  logic      history_ok;

  lbw_init_guard #(.LOCK_RUN(LOCK_RUN)) u_init (
    .clk        (clk),
    .rst        (rst),
    .init_en    (init_en),
    .lol        (lol),
    .pd_strobe  (pd_strobe),
    .history_ok (history_ok)
  );

  lbw_hs_fsm #(
    .LOCK_RUN     (LOCK_RUN),
    .ALIGN_TMO    (ALIGN_TMO),
    .REVERT_TICKS (REVERT_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .hs_enable  (hs_enable),
    .pbo_enable (pbo_enable),
    .lol        (lol),
    .pd_strobe  (pd_strobe),
    .in_window  (in_window),
    .align_done (align_done),
    .state      (hs_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      narrow_bw <= 1'b0;
      pd_enable <= 1'b1;
      align_req <= 1'b0;
    end else begin
      narrow_bw <= init_en && ((narrow_req && history_ok) || hs_forces_narrow(hs_state));
      pd_enable <= !hs_gates_pd(hs_state);
      align_req <= (hs_state == HS_ALIGN);
    end
  end
endmodule

// File: rtl/lbw_hitless_seq_chk.sv
module lbw_hitless_seq_chk #(
  parameter int ALIGN_TMO = 16
) (
  input logic clk,
  input logic rst,
  input logic init_en,
  input logic pbo_enable,
  input logic narrow_bw,
  input logic pd_enable,
  input logic align_req
);
  localparam int AW = $clog2(ALIGN_TMO + 2);

  logic [AW-1:0] align_len_q;

  always_ff @(posedge clk) begin
    if (rst || !align_req)
      align_len_q <= '0;
    else if (align_len_q != AW'(ALIGN_TMO + 1))
      align_len_q <= align_len_q + 1'b1;
  end

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pd_enable && !narrow_bw && !align_req)); // R1

  AST_INIT_OFF_WIDE: assert property (@(posedge clk) disable iff (rst)
    !init_en |=> !narrow_bw); // R2

  AST_GAP_IS_NARROW: assert property (@(posedge clk) disable iff (rst)
    !pd_enable |-> (narrow_bw || $past(!init_en))); // R6

  AST_ALIGN_PD_OFF: assert property (@(posedge clk) disable iff (rst)
    align_req |-> !pd_enable); // R7

  AST_ALIGN_NEEDS_PBO: assert property (@(posedge clk) disable iff (rst)
    $rose(align_req) |-> $past(pbo_enable)); // R7

  AST_ALIGN_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    align_req |-> (align_len_q < AW'(ALIGN_TMO))); // R8
endmodule

bind lbw_hitless_seq lbw_hitless_seq_chk #(.ALIGN_TMO(ALIGN_TMO)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .init_en    (init_en),
  .pbo_enable (pbo_enable),
  .narrow_bw  (narrow_bw),
  .pd_enable  (pd_enable),
  .align_req  (align_req)
);

// File: tb/tb_lbw_hitless_seq.sv
module tb_lbw_hitless_seq;
  localparam int LOCK_RUN     = 8;
  localparam int ALIGN_TMO    = 16;
  localparam int REVERT_TICKS = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_en = 1'b1, narrow_req = 1'b0, hs_enable = 1'b0, pbo_enable = 1'b0;
  logic lol = 1'b0, pd_strobe = 1'b0, in_window = 1'b0, align_done = 1'b0;
  logic narrow_bw, pd_enable, align_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    int    n;
    int    p;
    int    a;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  lbw_hitless_seq #(
    .LOCK_RUN(LOCK_RUN), .ALIGN_TMO(ALIGN_TMO), .REVERT_TICKS(REVERT_TICKS)
  ) dut (
    .clk(clk), .rst(rst), .init_en(init_en), .narrow_req(narrow_req),
    .hs_enable(hs_enable), .pbo_enable(pbo_enable), .lol(lol),
    .pd_strobe(pd_strobe), .in_window(in_window), .align_done(align_done),
    .narrow_bw(narrow_bw), .pd_enable(pd_enable), .align_req(align_req)
  );

  // monitor: pops each expected item and compares it with the live outputs
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      n_tests++;
      if ((e.n >= 0 && int'(narrow_bw) != e.n) ||
          (e.p >= 0 && int'(pd_enable) != e.p) ||
          (e.a >= 0 && int'(align_req) != e.a)) begin
        n_fail++;
        $display("FAIL %s: narrow/pd/align actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 e.tag, narrow_bw, pd_enable, align_req, e.n, e.p, e.a);
      end
    end
  end

  task automatic expect_out(input int n, input int p, input int a, input string tag);
    exp_t e;
    e.n = n; e.p = p; e.a = a; e.tag = tag;
    exp_q.push_back(e);
    #1;
  endtask

  task automatic tick(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic strobes(input int k, input logic win);
    for (int i = 0; i < k; i++) begin
      pd_strobe = 1'b1; in_window = win;
      @(negedge clk);
      pd_strobe = 1'b0; in_window = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    lol = 1'b0;
    strobes(LOCK_RUN, 1'b1);
    tick(REVERT_TICKS + 4);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    expect_out(0, 1, 0, "R1 reset values");

    // R4: no request, no sequence -> wide
    strobes(10, 1'b0);
    tick(2);
    expect_out(0, 1, 0, "R4 wide without request");

    // R2: override off pins wide even with a request and lock history
    init_en = 1'b0; narrow_req = 1'b1;
    strobes(10, 1'b0);
    tick(2);
    expect_out(0, 1, 0, "R2 init off with narrow request");

    // R3: lock history counting
    init_en = 1'b1;
    strobes(LOCK_RUN - 1, 1'b0);
    tick(3);
    expect_out(0, 1, 0, "R3 one strobe short");
    lol = 1'b1; tick(1); lol = 1'b0;
    strobes(1, 1'b0);
    tick(3);
    expect_out(0, 1, 0, "R3 lol restarts count");
    strobes(LOCK_RUN - 2, 1'b0);
    tick(3);
    expect_out(0, 1, 0, "R3 still short after restart");
    strobes(1, 1'b0);
    tick(2);
    expect_out(1, 1, 0, "R3 narrow after clean run");

    // R5: no arming before a locked strobe
    narrow_req = 1'b0;
    hs_enable = 1'b1; lol = 1'b1;
    tick(3);
    expect_out(0, 1, 0, "R5 lol high before lock");
    lol = 1'b0; tick(2); lol = 1'b1;
    tick(3);
    expect_out(0, 1, 0, "R5 lol rise while not armed");
    lol = 1'b0;
    strobes(1, 1'b0);
    tick(2);

    // R6/R9/R10: sequence without build-out
    lol = 1'b1;
    tick(2);
    expect_out(1, 0, 0, "R6 comparator gated and narrow");
    tick(1);
    expect_out(1, 1, 0, "R7 no build-out, no align request");
    lol = 1'b0;
    strobes(5, 1'b1);
    strobes(1, 1'b0);
    strobes(LOCK_RUN - 1, 1'b1);
    tick(REVERT_TICKS + 4);
    expect_out(1, 1, 0, "R9 out-of-window strobe restarted count");
    pd_strobe = 1'b1; in_window = 1'b1;
    tick(1);
    pd_strobe = 1'b0; in_window = 1'b0;
    tick(REVERT_TICKS + 1);
    expect_out(1, 1, 0, "R10 narrow through revert time");
    tick(1);
    expect_out(0, 1, 0, "R10 wide after revert time");
    lol = 1'b1;
    tick(2);
    expect_out(1, 0, 0, "R10 re-armed after revert");
    finish_run();
    expect_out(0, 1, 0, "R10 second sequence completes");

    // R7: build-out with handshake
    pbo_enable = 1'b1;
    lol = 1'b1;
    tick(3);
    expect_out(1, 0, 1, "R7 align request raised");
    tick(4);
    expect_out(1, 0, 1, "R7 waits for align_done");
    align_done = 1'b1;
    tick(3);
    expect_out(1, 1, 0, "R7 comparator back after align_done");
    align_done = 1'b0;
    finish_run();
    expect_out(0, 1, 0, "R7 sequence completes");

    // R8: build-out timeout
    lol = 1'b1;
    tick(3);
    expect_out(1, 0, 1, "R8 align request raised");
    tick(ALIGN_TMO - 4);
    expect_out(1, 0, 1, "R8 still waiting before timeout");
    tick(4);
    expect_out(1, 1, 0, "R8 released at timeout");
    finish_run();
    expect_out(0, 1, 0, "R8 sequence completes");

    // R2: override off also beats the hitless narrow setting
    init_en = 1'b0;
    lol = 1'b1;
    tick(2);
    expect_out(0, 0, 0, "R2 gated comparator stays wide");
    tick(1);
    expect_out(0, 0, 1, "R2 align phase stays wide");
    align_done = 1'b1; tick(3); align_done = 1'b0;
    finish_run();
    expect_out(0, 1, 0, "R2 sequence completes wide");

    // R5: disabled option ignores a rising lol
    hs_enable = 1'b0;
    tick(2);
    lol = 1'b1;
    tick(3);
    expect_out(0, 1, 0, "R5 disabled option ignores lol");

    wait (exp_q.size() == 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule